// File: doc/BRIEF.md
# Timer Clock Source Selector

This block decides, cycle by cycle, whether an 8-bit timer/counter advances. A 3-bit select field picks one of eight sources. The timer can be stopped. It can count on every system clock. It can count on one of four divided rates taken from a shared free-running prescaler. It can also count on either the falling or the rising transitions of an external pin. The result is a count-enable strobe, one system clock wide, that the counter qualifies its increment with.

The external pin is brought into the clock domain through a two-flop synchronizer, and its transitions are found on the synchronized level. There is no direction qualifier, so transitions are counted even when the pin is driven as an output. Software can therefore toggle the pin to step the counter by hand. The select field is registered. A new code takes over at the next clock edge, and a pulse is never issued twice across a switch.

Top module: `tclk_source_sel`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `count_en` is low.
- R2: Select code 000 (stopped) keeps `count_en` low.
- R3: Select code 001 holds `count_en` high on every cycle it is in force, apart from the single switch cycle described in R8.
- R4: Select codes 010, 011, 100 and 101 give exactly one single-cycle pulse per 8, 64, 256 and 1024 clock cycles respectively. The pulses come from one shared 10-bit counter that starts at zero after reset, and fire in the cycle where the counter's low 3, 6, 8 or 10 bits are all ones.
- R5: Select code 110 gives one pulse per falling transition of `pin_raw`. The pulse comes in the cycle after the second rising clock edge at which the new low level is sampled.
- R6: Select code 111 gives one pulse per rising transition of `pin_raw`, with the same latency as R5.
- R7: A select code sampled at a clock edge governs `count_en` from that edge onward.
- R8: When the select code in force differs from the one in force in the previous cycle, and `count_en` was high in that previous cycle, `count_en` is low.
- R9: `count_en` is never high in two consecutive cycles unless code 001 was in force in both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 3 | Count source select code |
| pin_raw | input | 1 | Unsynchronized external count pin |
| count_en | output | 1 | Single-cycle count-enable strobe |

## Verification
The bench builds the block with its default parameters: a 10-bit prescaler and two synchronizer stages. With these values even the slowest tap, one pulse per 1024 cycles, fits inside one full prescaler period. Counting pulses over a window of 1024 cycles therefore gives an exact expected total for every divide ratio, whatever the phase of the window. The bench also uses its own copy of the prescaler phase to time a switch out of the every-cycle mode so that it lands on a tap pulse. This places the duplicate-suppression case on a known cycle.

// File: rtl/tclk_pkg.sv
package tclk_pkg;

    typedef enum logic [2:0] {
        SRC_OFF      = 3'd0,
        SRC_SYS      = 3'd1,
        SRC_DIV8     = 3'd2,
        SRC_DIV64    = 3'd3,
        SRC_DIV256   = 3'd4,
        SRC_DIV1024  = 3'd5,
        SRC_PIN_FALL = 3'd6,
        SRC_PIN_RISE = 3'd7
    } src_sel_e;

    localparam int unsigned NUM_TAPS = 4;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edge_t;

    // number of low prescaler bits that must be all ones for tap idx
    function automatic int unsigned tap_log2(input int unsigned idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tclk_prescaler.sv
module tclk_prescaler
    import tclk_pkg::*;
#(
    parameter int unsigned PRE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    output logic [NUM_TAPS-1:0] taps
);

    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        localparam int unsigned LW = tap_log2(i);
        if (LW <= PRE_W) begin : g_ok
            assign taps[i] = &cnt_q[LW-1:0];
        end else begin : g_short
            assign taps[i] = &cnt_q;
        end
    end

endmodule

// File: rtl/tclk_pin_sync.sv
module tclk_pin_sync
    import tclk_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_raw,
    output pin_edge_t edges
);

    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= pin_raw;
        end
    end

    for (genvar i = 1; i < CHAIN_W; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q[i] <= 1'b0;
            end else begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    logic level_now;
    logic level_prev;

    assign level_now  = chain_q[SYNC_STAGES-1];
    assign level_prev = chain_q[SYNC_STAGES];

    always_comb begin
        edges.rise = level_now & ~level_prev;
        edges.fall = ~level_now & level_prev;
    end

endmodule

// File: rtl/tclk_src_mux.sv
module tclk_src_mux
    import tclk_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          src_sel,
    input  logic [NUM_TAPS-1:0] taps,
    input  pin_edge_t           edges,
    output logic                count_en
);

    src_sel_e sel_q;
    src_sel_e sel_prev_q;
    logic     en_prev_q;
    logic     en_raw;
    logic     switched;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q      <= SRC_OFF;
            sel_prev_q <= SRC_OFF;
            en_prev_q  <= 1'b0;
        end else begin
            sel_q      <= src_sel_e'(src_sel);
            sel_prev_q <= sel_q;
            en_prev_q  <= count_en;
        end
    end

    always_comb begin
        case (sel_q)
            SRC_OFF:      en_raw = 1'b0;
            SRC_SYS:      en_raw = 1'b1;
            SRC_DIV8:     en_raw = taps[0];
            SRC_DIV64:    en_raw = taps[1];
            SRC_DIV256:   en_raw = taps[2];
            SRC_DIV1024:  en_raw = taps[3];
            SRC_PIN_FALL: en_raw = edges.fall;
            SRC_PIN_RISE: en_raw = edges.rise;
            default:      en_raw = 1'b0;
        endcase
    end

    assign switched = (sel_q != sel_prev_q);
    assign count_en = en_raw & ~(switched & en_prev_q);

endmodule

// File: rtl/tclk_source_sel.sv
module tclk_source_sel
    import tclk_pkg::*;
#(
    parameter int unsigned PRE_W       = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] src_sel,
    input  logic       pin_raw,
    output logic       count_en
);

    logic [NUM_TAPS-1:0] taps;
    pin_edge_t           edges;

    tclk_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .taps (taps)
    );

    tclk_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_raw (pin_raw),
        .edges   (edges)
    );

    tclk_src_mux u_mux (
        .clk      (clk),
        .rst      (rst),
        .src_sel  (src_sel),
        .taps     (taps),
        .edges    (edges),
        .count_en (count_en)
    );

endmodule

// File: rtl/tclk_source_sel_chk.sv
module tclk_source_sel_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] src_sel,
    input logic       count_en
);

    // R1: reset silences the strobe on the following cycle
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> !count_en);

    // R2: stopped code never pulses
    a_r2_stopped: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(src_sel) == 3'd0) |-> !count_en);

    // R3: undivided clock keeps the strobe high once settled
    a_r3_every_cycle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(src_sel) == 3'd1
         && $past(src_sel, 2) == 3'd1) |-> count_en);

    // R8: no repeated pulse across a change of select code
    a_r8_no_dup_switch: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(src_sel) != $past(src_sel, 2)
         && $past(count_en)) |-> !count_en);

    // R9: back-to-back highs only with the undivided code held
    a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(count_en) && count_en)
        |-> ($past(src_sel) == 3'd1 && $past(src_sel, 2) == 3'd1));

endmodule

bind tclk_source_sel tclk_source_sel_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .src_sel  (src_sel),
    .count_en (count_en)
);

// File: tb/tb_tclk_source_sel.sv
module tb_tclk_source_sel;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] src_sel = 3'd0;
    logic       pin_raw = 1'b0;
    logic       count_en;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    tclk_source_sel dut (
        .clk      (clk),
        .rst      (rst),
        .src_sel  (src_sel),
        .pin_raw  (pin_raw),
        .count_en (count_en)
    );

    // ---------------- behavioural reference ----------------
    int m_cnt   = 0;
    int m_selq  = 0;
    int m_selqq = 0;
    bit m_prev  = 0;
    bit m_hist[$] = '{0, 0, 0};   // [0] newest pin sample
    bit seen_edge = 0;

    function automatic bit model_en();
        bit raw;
        bit now_lvl  = m_hist[1];
        bit prev_lvl = m_hist[2];
        case (m_selq)
            0: raw = 0;
            1: raw = 1;
            2: raw = (m_cnt % 8) == 7;
            3: raw = (m_cnt % 64) == 63;
            4: raw = (m_cnt % 256) == 255;
            5: raw = (m_cnt % 1024) == 1023;
            6: raw = !now_lvl && prev_lvl;
            default: raw = now_lvl && !prev_lvl;
        endcase
        return raw && !((m_selq != m_selqq) && m_prev);
    endfunction

    function automatic string req_tag();
        if (m_selq != m_selqq) return "R8";
        case (m_selq)
            0: return "R2";
            1: return "R3";
            6: return "R5";
            7: return "R6";
            default: return "R4";
        endcase
    endfunction

    always @(posedge clk) begin
        seen_edge = 1;
        if (rst) begin
            m_cnt = 0; m_selq = 0; m_selqq = 0; m_prev = 0;
            m_hist = '{0, 0, 0};
        end else begin
            m_prev  = model_en();
            m_selqq = m_selq;
            m_selq  = int'(src_sel);
            m_cnt   = (m_cnt + 1) % 1024;
            m_hist.push_front(pin_raw);
            void'(m_hist.pop_back());
        end
    end

    task automatic check(input string req, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        cycles++;
        if (seen_edge && !done) begin
            if (rst) check("R1", count_en, 1'b0);
            else     check(req_tag(), count_en, model_en());
        end
    end

    task automatic count_window(input int n, output int pulses, output int pairs);
        bit last = 0;
        pulses = 0; pairs = 0;
        repeat (n) begin
            @(negedge clk);
            if (count_en) pulses++;
            if (count_en && last) pairs++;
            last = count_en;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int p, q;
        repeat (4) @(negedge clk);
        check("R1", count_en, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", count_en, 1'b0);

        // R2: stopped
        count_window(300, p, q);
        check_int("R2", p, 0);

        // R7: new code takes over at the next edge
        src_sel = 3'd1;
        @(negedge clk);
        check("R7", count_en, 1'b1);
        count_window(100, p, q);
        check_int("R3", p, 100);

        // R8: leave the every-cycle mode right onto a /8 tap pulse
        while ((m_cnt % 8) != 6) @(negedge clk);
        src_sel = 3'd2;
        @(negedge clk);
        check("R8", count_en, 1'b0);

        // R4 / R9: every tap over one full prescaler period
        count_window(1024, p, q);
        check_int("R4", p, 128);
        check_int("R9", q, 0);
        src_sel = 3'd3;  repeat (2) @(negedge clk);
        count_window(1024, p, q);
        check_int("R4", p, 16);
        src_sel = 3'd4;  repeat (2) @(negedge clk);
        count_window(1024, p, q);
        check_int("R4", p, 4);
        src_sel = 3'd5;  repeat (2) @(negedge clk);
        count_window(1024, p, q);
        check_int("R4", p, 1);

        // R5: falling edges, latency
        src_sel = 3'd6;
        pin_raw = 1'b1;
        repeat (6) @(negedge clk);
        pin_raw = 1'b0;
        @(negedge clk);
        check("R5", count_en, 1'b0);
        @(negedge clk);
        check("R5", count_en, 1'b1);
        @(negedge clk);
        check("R5", count_en, 1'b0);
        p = 0;
        for (int k = 0; k < 10; k++) begin
            pin_raw = ~pin_raw;
            repeat (3) begin @(negedge clk); if (count_en) p++; end
        end
        repeat (4) begin @(negedge clk); if (count_en) p++; end
        check_int("R5", p, 5);

        // R6: rising edges, pin toggled every cycle
        src_sel = 3'd7;
        repeat (4) @(negedge clk);
        pin_raw = 1'b0;
        repeat (4) @(negedge clk);
        pin_raw = 1'b1;
        @(negedge clk);
        check("R6", count_en, 1'b0);
        @(negedge clk);
        check("R6", count_en, 1'b1);
        pin_raw = 1'b0;
        repeat (4) @(negedge clk);
        begin
            bit last = 0;
            p = 0; q = 0;
            for (int k = 0; k < 20; k++) begin
                pin_raw = ~pin_raw;
                @(negedge clk);
                if (count_en) p++;
                if (count_en && last) q++;
                last = count_en;
            end
            repeat (4) begin
                @(negedge clk);
                if (count_en) p++;
                if (count_en && last) q++;
                last = count_en;
            end
        end
        check_int("R6", p, 10);
        check_int("R9", q, 0);

        // back to stopped
        src_sel = 3'd0;
        repeat (2) @(negedge clk);
        count_window(50, p, q);
        check_int("R2", p, 0);

        finish_run();
    end

endmodule